// File: doc/BRIEF.md
# Floating-Point Status and Rounding-Mode Unit

This block keeps the 8-bit control and status word of a single-precision floating-point unit. The upper three bits hold the dynamic rounding mode. The lower five bits are sticky exception flags, which collect whatever the arithmetic datapath reports for each completed operation. Only software clears them.

For every issued operation, the block resolves the 3-bit rounding code carried in the instruction into the mode the datapath must use. The escape code 111 redirects the lookup to the stored dynamic field. The block flags the operation as illegal when the resolved code is not a defined mode. Software reaches the register through a selector that exposes three views: the whole word, the flags alone, or the rounding mode alone. The block also supplies the datapath with the canonical quiet NaN bit pattern.

Top module: `fpcsr_unit`

## Requirements
- R1: While `rst_ni` is low, the whole register is zero. After reset, a full-view read returns 0x00.
- R2: Operation flags map to accrued bits as follows: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. On the clock edge of an accepted operation (`op_valid_i` high and not illegal), `op_flags_i` is ORed into the accrued bits.
- R3: Accrued flag bits stay set until a CSR write whose view covers the flags.
- R4: Selector `csr_sel_i` chooses the view. 00 is the full word, with the rounding mode in bits 7:5 and the flags in 4:0. 01 is the flags in data bits 4:0. 10 is the rounding mode in data bits 2:0. Reads are combinational from the stored value. Writes take effect at the clock edge.
- R5: In the flags and rounding-mode views, data bits outside the field read as zero and are ignored on write. Selector 11 reads zero, and a write through it changes nothing.
- R6: The resolved mode `eff_rm_o` equals `op_rm_i`, except that code 111 yields the stored dynamic field as it was before any same-cycle write. The codes are 000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest with ties away from zero.
- R7: `illegal_o` is high when `op_valid_i` is high and the resolved code is 101, 110 or 111. This includes a dynamic lookup that finds one of those values. The flags of an illegal operation are not accrued.
- R8: When a flag-covering CSR write and an accepted operation fall in the same cycle, the new flags equal the written value ORed with the operation's flags.
- R9: `canon_nan_o` is constantly 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_sel_i | input | 2 | CSR view selector |
| csr_wdata_i | input | 8 | CSR write data |
| csr_rdata_o | output | 8 | CSR read data for the selected view |
| op_valid_i | input | 1 | An operation is issued or completes this cycle |
| op_rm_i | input | 3 | Rounding code from the instruction |
| op_flags_i | input | 5 | Exception flags reported by the datapath |
| eff_rm_o | output | 3 | Resolved rounding mode |
| illegal_o | output | 1 | Resolved rounding mode is undefined |
| canon_nan_o | output | 32 | Canonical quiet NaN pattern |

## Verification
The bench targets the following corner cases:
- Dynamic lookups where the stored field holds 101 or 111. A resolver that tests only the instruction code would pass these lookups as legal.
- Illegal operations that carry flags. A design that accrues them would corrupt the sticky bits.
- Cycles where a flag write coincides with a flag report. Getting the ordering wrong either loses the report or loses the clear.
- Writes through the narrow views with junk in the unused data bits, and writes through the reserved selector. A loose field decode shows up there as altered neighbouring bits.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int FLAG_W = 5;
  localparam int RM_W   = 3;
  localparam int CSR_W  = FLAG_W + RM_W;
  localparam int SEL_W  = 2;
  localparam int NAN_W  = 32;
  localparam logic [NAN_W-1:0] CANON_NAN = 32'h7FC0_0000;
  localparam logic [RM_W-1:0]  RM_DYN    = 3'b111;
  localparam logic [RM_W-1:0]  RM_MAX_OK = 3'b100;

  typedef enum logic [SEL_W-1:0] {
    SEL_FULL  = 2'b00,
    SEL_FLAGS = 2'b01,
    SEL_RM    = 2'b10,
    SEL_NONE  = 2'b11
  } csr_sel_e;
endpackage

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve
  import fpcsr_pkg::*;
(
  input  logic            valid_i,
  input  logic [RM_W-1:0] inst_rm_i,
  input  logic [RM_W-1:0] dyn_rm_i,
  output logic [RM_W-1:0] eff_rm_o,
  output logic            illegal_o
);
  always_comb begin
    eff_rm_o  = (inst_rm_i == RM_DYN) ? dyn_rm_i : inst_rm_i;
    illegal_o = valid_i && (eff_rm_o > RM_MAX_OK);
  end
endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state
  import fpcsr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [CSR_W-1:0]  wdata_i,
  input  logic              acc_i,
  input  logic [FLAG_W-1:0] acc_flags_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic [RM_W-1:0]   frm_o
);
  logic [FLAG_W-1:0] flags_q, flags_d, flags_base;
  logic [RM_W-1:0]   frm_q, frm_d;
  logic              wr_flags, wr_rm;

  assign wr_flags = wr_i && (sel_i == SEL_FULL || sel_i == SEL_FLAGS);
  assign wr_rm    = wr_i && (sel_i == SEL_FULL || sel_i == SEL_RM);

  always_comb begin
    // write lands first, then this cycle's report is merged on top
    flags_base = wr_flags ? wdata_i[FLAG_W-1:0] : flags_q;
    flags_d    = flags_base | (acc_i ? acc_flags_i : '0);
    frm_d      = frm_q;
    if (wr_rm)
      frm_d = (sel_i == SEL_FULL) ? wdata_i[CSR_W-1:FLAG_W] : wdata_i[RM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      frm_q   <= '0;
    end else begin
      flags_q <= flags_d;
      frm_q   <= frm_d;
    end
  end

  assign flags_o = flags_q;
  assign frm_o   = frm_q;

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
  a_r7_no_accrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !wr_flags) |=> $stable(flags_q));
  a_r5_rm_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rm |=> $stable(frm_q));
  a_r8_write_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flags |=> ((flags_q & $past(wdata_i[FLAG_W-1:0])) == $past(wdata_i[FLAG_W-1:0])));
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
  import fpcsr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic [1:0]  csr_sel_i,
  input  logic [7:0]  csr_wdata_i,
  output logic [7:0]  csr_rdata_o,
  input  logic        op_valid_i,
  input  logic [2:0]  op_rm_i,
  input  logic [4:0]  op_flags_i,
  output logic [2:0]  eff_rm_o,
  output logic        illegal_o,
  output logic [31:0] canon_nan_o
);
  logic [FLAG_W-1:0] flags;
  logic [RM_W-1:0]   frm;
  logic              acc;

  fpcsr_rm_resolve u_resolve (
    .valid_i   (op_valid_i),
    .inst_rm_i (op_rm_i),
    .dyn_rm_i  (frm),
    .eff_rm_o  (eff_rm_o),
    .illegal_o (illegal_o)
  );

  assign acc = op_valid_i && !illegal_o;

  fpcsr_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (csr_we_i),
    .sel_i       (csr_sel_i),
    .wdata_i     (csr_wdata_i),
    .acc_i       (acc),
    .acc_flags_i (op_flags_i),
    .flags_o     (flags),
    .frm_o       (frm)
  );

  always_comb begin
    unique case (csr_sel_i)
      SEL_FULL:  csr_rdata_o = {frm, flags};
      SEL_FLAGS: csr_rdata_o = {{(CSR_W-FLAG_W){1'b0}}, flags};
      SEL_RM:    csr_rdata_o = {{(CSR_W-RM_W){1'b0}}, frm};
      default:   csr_rdata_o = '0;
    endcase
  end

  assign canon_nan_o = CANON_NAN;

  a_r9_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    canon_nan_o == 32'h7FC0_0000);
endmodule

// File: tb/fpcsr_unit_bench.sv
`timescale 1ns/1ps
module fpcsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        csr_we_i = 1'b0;
  logic [1:0]  csr_sel_i = 2'b00;
  logic [7:0]  csr_wdata_i = '0;
  logic [7:0]  csr_rdata_o;
  logic        op_valid_i = 1'b0;
  logic [2:0]  op_rm_i = '0;
  logic [4:0]  op_flags_i = '0;
  logic [2:0]  eff_rm_o;
  logic        illegal_o;
  logic [31:0] canon_nan_o;

  always #2.5 clk = ~clk;

  fpcsr_unit u_fpcsr_unit (
    .clk_i(clk), .rst_ni(rst_ni), .csr_we_i(csr_we_i), .csr_sel_i(csr_sel_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .op_valid_i(op_valid_i),
    .op_rm_i(op_rm_i), .op_flags_i(op_flags_i), .eff_rm_o(eff_rm_o),
    .illegal_o(illegal_o), .canon_nan_o(canon_nan_o)
  );

  typedef struct {
    logic [7:0] rdata;
    logic [2:0] eff;
    logic       ill;
    string      tag;
  } item_t;

  item_t exp_q[$];
  event  ev_chk;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  logic [4:0] m_flags = '0;
  logic [2:0] m_frm   = '0;

  // monitor: compares outputs against the queued expectation
  initial forever begin
    @(ev_chk);
    #0.5;
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      checks++;
      if (csr_rdata_o !== it.rdata || eff_rm_o !== it.eff || illegal_o !== it.ill) begin
        fails++;
        $display("FAIL %s: got rdata=%h eff=%0d ill=%0b, expected rdata=%h eff=%0d ill=%0b",
                 it.tag, csr_rdata_o, eff_rm_o, illegal_o, it.rdata, it.eff, it.ill);
      end
    end
  end

  function automatic logic [7:0] view(input logic [1:0] sel);
    case (sel)
      2'b00:   return {m_frm, m_flags};
      2'b01:   return {3'b000, m_flags};
      2'b10:   return {5'b00000, m_frm};
      default: return 8'h00;
    endcase
  endfunction

  // driver: one cycle of stimulus, expectation pushed, model advanced at the edge
  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] wd,
                      input logic v, input logic [2:0] rm, input logic [4:0] fl,
                      input string tag);
    item_t it;
    logic [2:0] eff;
    logic ill;
    @(negedge clk);
    csr_we_i = we; csr_sel_i = sel; csr_wdata_i = wd;
    op_valid_i = v; op_rm_i = rm; op_flags_i = fl;
    eff = (rm == 3'b111) ? m_frm : rm;
    ill = v && (eff > 3'd4);
    it.rdata = view(sel); it.eff = eff; it.ill = ill; it.tag = tag;
    exp_q.push_back(it);
    -> ev_chk;
    @(posedge clk);
    if (we && (sel == 2'b00 || sel == 2'b01)) m_flags = wd[4:0];
    if (we && sel == 2'b00) m_frm = wd[7:5];
    if (we && sel == 2'b10) m_frm = wd[2:0];
    if (v && !ill) m_flags = m_flags | fl;
  endtask

  task automatic rd(input logic [1:0] sel, input string tag);
    step(1'b0, sel, 8'h00, 1'b0, 3'b000, 5'h00, tag);
  endtask

  initial begin
    #1;
    begin
      item_t it;
      it.rdata = 8'h00; it.eff = 3'd0; it.ill = 1'b0; it.tag = "R1 reset view";
      exp_q.push_back(it);
      -> ev_chk;
    end
    #20;
    @(negedge clk) rst_ni = 1'b1;
    rd(2'b00, "R1 full read after reset");
    checks++;
    if (canon_nan_o !== 32'h7FC00000) begin
      fails++;
      $display("FAIL R9: got %h expected 7fc00000", canon_nan_o);
    end
    // R2 accrual with distinct bit patterns
    step(0, 2'b00, 0, 1, 3'b000, 5'b10000, "R2 invalid op");
    step(0, 2'b00, 0, 1, 3'b001, 5'b00001, "R2 inexact");
    rd(2'b01, "R2 flags view 10001");
    step(0, 2'b00, 0, 1, 3'b100, 5'b01010, "R2 dz+uf");
    rd(2'b00, "R3 sticky full read");
    step(0, 2'b00, 0, 1, 3'b011, 5'b00000, "R3 zero report keeps bits");
    rd(2'b01, "R3 sticky flags");
    // R4/R5 narrow views with junk
    step(1, 2'b10, 8'hFA, 0, 0, 0, "R4 write rm view junk");
    rd(2'b00, "R5 rm view changes only frm");
    rd(2'b10, "R4 rm view read");
    step(1, 2'b01, 8'hE4, 0, 0, 0, "R4 write flags view junk");
    rd(2'b00, "R5 flags view changes only flags");
    step(1, 2'b11, 8'hFF, 0, 0, 0, "R5 reserved selector write");
    rd(2'b00, "R5 reserved write ignored");
    rd(2'b11, "R5 reserved reads zero");
    // R6 dynamic resolution for each legal stored value
    for (int k = 0; k < 5; k++) begin
      step(1, 2'b10, 8'(k), 0, 0, 0, "R4 set frm");
      step(0, 2'b00, 0, 1, 3'b111, 5'b00100, "R6 dynamic lookup");
    end
    step(0, 2'b00, 0, 1, 3'b010, 0, "R6 static code direct");
    // R6 dynamic uses pre-write field
    step(1, 2'b00, 8'h20, 1, 3'b111, 5'b00001, "R6/R8 same-cycle write");
    rd(2'b00, "R8 write then OR");
    // R7 illegal static codes
    step(1, 2'b01, 8'h00, 0, 0, 0, "R3 clear flags");
    step(0, 2'b00, 0, 1, 3'b101, 5'b11111, "R7 static 101");
    step(0, 2'b00, 0, 1, 3'b110, 5'b11111, "R7 static 110");
    rd(2'b01, "R7 no accrual from illegal");
    // R7 dynamic illegal
    step(1, 2'b00, 8'hA0, 0, 0, 0, "R4 frm=101");
    step(0, 2'b00, 0, 1, 3'b111, 5'b00010, "R7 dynamic 101");
    step(1, 2'b10, 8'h07, 0, 0, 0, "R4 frm=111");
    step(0, 2'b00, 0, 1, 3'b111, 5'b01000, "R7 dynamic 111");
    step(0, 2'b00, 0, 0, 3'b111, 5'b01000, "R7 no valid no illegal");
    rd(2'b00, "R7 flags untouched");
    // R8 flags-view write clearing while report arrives
    step(0, 2'b00, 0, 1, 3'b000, 5'b11000, "R2 set high bits");
    step(1, 2'b01, 8'h01, 1, 3'b000, 5'b00100, "R8 clear+report");
    rd(2'b01, "R8 merged flags");
    // R1 async reset mid-run
    @(negedge clk) rst_ni = 1'b0;
    m_flags = '0; m_frm = '0;
    #7;
    @(negedge clk) rst_ni = 1'b1;
    rd(2'b00, "R1 reset clears register");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule